// File: doc/BRIEF.md
# Six-Channel Paired-Sampling Converter Host Controller

This block sits on the host side of a six-channel analog-to-digital converter whose inputs are sampled in three pairs (channels 1–2, 3–4 and 5–6). A request names any non-empty subset of the pairs. The controller raises one start strobe for each chosen pair and holds it while the converter reports that it is busy. Once the busy flag has risen and fallen again, it fetches the results of the started pairs one after another over a 16-bit parallel bus. Each fetch uses an active-low chip-select together with an active-low read strobe. Each result leaves the block as a one-cycle valid pulse with its channel index and data.

The same bus also carries an 8-bit configuration byte into the converter. The controller drives the byte on the upper half of the bus while chip-select and the write strobe are both low, and it releases the bus at all other times. Strobe low times, the recovery gap between strobes and the busy timeout are parameters counted in system clocks. Requests that arrive at a bad moment are refused and flagged. A conversion whose busy flag never clears is abandoned and flagged.

Top module: `adc6_host_ctrl`

## Requirements
- R1: After reset, cs_n, rd_n and wr_n are high, cnv_start is 0, wr_byte_oe, res_valid, err_reject and err_timeout are low, and idle is high.
- R2: An accepted conversion request sets cnv_start to conv_pairs in the cycle after the request, where bit p starts pair p (bit 0 is channels 1–2, bit 1 is channels 3–4, bit 2 is channels 5–6). The strobes are held for as long as adc_busy is high.
- R3: No read strobe is issued until adc_busy has been seen high and then low again. cnv_start is 0 throughout readback.
- R4: Readback fetches only the channels of the started pairs, in ascending channel order, one read strobe per channel. res_chan carries the channel number minus one (0..5). res_data carries the bus value present at the end of the strobe, and res_valid pulses in the cycle after rd_n rises.
- R5: Each read strobe keeps rd_n and cs_n low for exactly RD_LOW_CYC cycles. Consecutive read strobes are separated by exactly RECOV_CYC high cycles.
- R6: A configuration request in idle produces one write strobe that keeps wr_n and cs_n low for exactly WR_LOW_CYC cycles. cfg_byte is driven on wr_byte during the strobe, and wr_byte_oe is high only then. rd_n and wr_n are never low together.
- R7: A conversion request that arrives while the block is not idle, while adc_busy is high, or with conv_pairs equal to 0 is refused. err_reject pulses for one cycle in the following cycle, and the strobes are left unchanged.
- R8: If the busy flag has not completed its high-then-low sequence within TIMEOUT_CYC cycles of the start, err_timeout pulses, cnv_start returns to 0, no results are read and the block returns to idle. With the request presented at cycle 0, the pulse is seen in cycle TIMEOUT_CYC+1.
- R9: When a conversion request and a configuration request arrive in the same idle cycle, the conversion is served and the configuration request is dropped without any write strobe.
- R10: idle is high exactly when no conversion, readback or write is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_req | input | 1 | One-cycle conversion request |
| conv_pairs | input | 3 | Pairs to convert, one bit per pair |
| cfg_req | input | 1 | One-cycle configuration write request |
| cfg_byte | input | 8 | Configuration byte to write |
| res_valid | output | 1 | One-cycle result strobe |
| res_chan | output | 3 | Channel index of the result, 0..5 |
| res_data | output | 16 | Result value |
| err_reject | output | 1 | Pulse: conversion request refused |
| err_timeout | output | 1 | Pulse: busy timeout, conversion aborted |
| idle | output | 1 | High when no operation is in progress |
| cnv_start | output | 3 | Per-pair conversion start strobes |
| adc_busy | input | 1 | Converter busy flag |
| cs_n | output | 1 | Active-low chip select |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| wr_byte | output | 8 | Byte for bus bits 15:8 during a write |
| wr_byte_oe | output | 1 | Output enable for bus bits 15:8 |
| bus_i | input | 16 | Data read from the parallel bus |

## Verification
The start strobes are due one cycle after the request. A refusal pulse is likewise due one cycle after the refused request. The timeout pulse is due exactly TIMEOUT_CYC+1 cycles after the request, and each result pulse falls one cycle after its read strobe rises. The bench drives inputs on falling edges and samples at the falling edge that follows the expected rising edge, so every check falls on a fixed cycle. Strobe widths and recovery gaps are measured by counting low and high runs at falling edges and comparing them with the parameters. A behavioural converter in the bench raises busy one cycle after a start edge and serves results in channel order.

// File: rtl/adc6_pkg.sv
package adc6_pkg;
   localparam int PAIRS_PER_CONV = 3;
   localparam int CH_PER_PAIR    = 2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT_HI,
      ST_WAIT_LO,
      ST_RD_LOW,
      ST_RD_REC,
      ST_WR_LOW,
      ST_WR_REC
   } adc6_state_e;
endpackage

// File: rtl/adc6_cycle_timer.sv
module adc6_cycle_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/adc6_busy_watch.sv
module adc6_busy_watch #(
   parameter int LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic hit
);
   localparam int W = $clog2(LIMIT + 1);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (!run) cnt_q <= '0;
      else if (!hit) cnt_q <= cnt_q + 1'b1;
   end

   assign hit = run && (cnt_q == W'(LIMIT - 1));
endmodule

// File: rtl/adc6_pick_first.sv
module adc6_pick_first #(
   parameter int N = 6
) (
   input  logic [N-1:0]         mask,
   output logic                 any,
   output logic [$clog2(N)-1:0] idx
);
   localparam int IW = $clog2(N);
   logic [N:0]   seen;
   logic [N-1:0] first;

   assign seen[0] = 1'b0;
   for (genvar i = 0; i < N; i++) begin : g_chain
      assign first[i]  = mask[i] & ~seen[i];
      assign seen[i+1] = seen[i] | mask[i];
   end
   assign any = seen[N];

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++)
         if (first[i]) idx = idx | IW'(i);
   end
endmodule

// File: rtl/adc6_host_ctrl.sv
module adc6_host_ctrl
   import adc6_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int CFG_W       = 8,
   parameter int NUM_PAIRS   = PAIRS_PER_CONV,
   parameter int RD_LOW_CYC  = 3,
   parameter int WR_LOW_CYC  = 3,
   parameter int RECOV_CYC   = 2,
   parameter int TIMEOUT_CYC = 1000
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   conv_req,
   input  logic [NUM_PAIRS-1:0]   conv_pairs,
   input  logic                   cfg_req,
   input  logic [CFG_W-1:0]       cfg_byte,
   output logic                   res_valid,
   output logic [$clog2(NUM_PAIRS*CH_PER_PAIR)-1:0] res_chan,
   output logic [DATA_W-1:0]      res_data,
   output logic                   err_reject,
   output logic                   err_timeout,
   output logic                   idle,
   output logic [NUM_PAIRS-1:0]   cnv_start,
   input  logic                   adc_busy,
   output logic                   cs_n,
   output logic                   rd_n,
   output logic                   wr_n,
   output logic [CFG_W-1:0]       wr_byte,
   output logic                   wr_byte_oe,
   input  logic [DATA_W-1:0]      bus_i
);
   localparam int NUM_CH  = NUM_PAIRS * CH_PER_PAIR;
   localparam int CH_W    = $clog2(NUM_CH);
   localparam int LOW_MAX = (RD_LOW_CYC > WR_LOW_CYC) ? RD_LOW_CYC : WR_LOW_CYC;
   localparam int TMR_MAX = (LOW_MAX > RECOV_CYC) ? LOW_MAX : RECOV_CYC;
   localparam int TMR_W   = $clog2(TMR_MAX + 1);

   if (RD_LOW_CYC < 1 || WR_LOW_CYC < 1 || RECOV_CYC < 1)
      $error("strobe and recovery lengths must be at least one cycle");
   if (2 * CFG_W != DATA_W)
      $error("configuration byte must fill the upper half of the bus");
   if (TIMEOUT_CYC < 2)
      $error("timeout must be at least two cycles");

   adc6_state_e          state_q, state_d;
   logic [NUM_PAIRS-1:0] pairs_q;
   logic [NUM_CH-1:0]    pend_q, req_chans;
   logic [CH_W-1:0]      cur_ch_q, nxt_ch;
   logic [CFG_W-1:0]     cfg_q;
   logic                 nxt_any, tmr_done, tmo_hit, waiting, req_ok;
   logic [TMR_W-1:0]     tmr_val;

   always_comb begin
      for (int p = 0; p < NUM_PAIRS; p++)
         for (int c = 0; c < CH_PER_PAIR; c++)
            req_chans[p*CH_PER_PAIR + c] = conv_pairs[p];
   end

   assign waiting = (state_q == ST_WAIT_HI) || (state_q == ST_WAIT_LO);
   assign req_ok  = conv_req && (state_q == ST_IDLE) && !adc_busy && (conv_pairs != '0);

   adc6_pick_first #(.N(NUM_CH)) u_pick (
      .mask (pend_q),
      .any  (nxt_any),
      .idx  (nxt_ch)
   );

   adc6_busy_watch #(.LIMIT(TIMEOUT_CYC)) u_watch (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (waiting),
      .hit   (tmo_hit)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (req_ok)               state_d = ST_WAIT_HI;
                     else if (cfg_req && !conv_req) state_d = ST_WR_LOW;
         ST_WAIT_HI: if (tmo_hit)              state_d = ST_IDLE;
                     else if (adc_busy)        state_d = ST_WAIT_LO;
         ST_WAIT_LO: if (tmo_hit)              state_d = ST_IDLE;
                     else if (!adc_busy)       state_d = ST_RD_LOW;
         ST_RD_LOW:  if (tmr_done)             state_d = ST_RD_REC;
         ST_RD_REC:  if (tmr_done)             state_d = nxt_any ? ST_RD_LOW : ST_IDLE;
         ST_WR_LOW:  if (tmr_done)             state_d = ST_WR_REC;
         ST_WR_REC:  if (tmr_done)             state_d = ST_IDLE;
         default:                              state_d = ST_IDLE;
      endcase
   end

   always_comb begin
      unique case (state_d)
         ST_RD_LOW: tmr_val = TMR_W'(RD_LOW_CYC - 1);
         ST_WR_LOW: tmr_val = TMR_W'(WR_LOW_CYC - 1);
         default:   tmr_val = TMR_W'(RECOV_CYC - 1);
      endcase
   end

   adc6_cycle_timer #(.W(TMR_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (state_d != state_q),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         pairs_q     <= '0;
         pend_q      <= '0;
         cur_ch_q    <= '0;
         cfg_q       <= '0;
         res_valid   <= 1'b0;
         res_chan    <= '0;
         res_data    <= '0;
         err_reject  <= 1'b0;
         err_timeout <= 1'b0;
      end else begin
         state_q     <= state_d;
         res_valid   <= 1'b0;
         err_reject  <= conv_req && !req_ok;
         err_timeout <= waiting && tmo_hit;
         if (state_q == ST_IDLE && req_ok) begin
            pairs_q <= conv_pairs;
            pend_q  <= req_chans;
         end
         if (state_q == ST_IDLE && state_d == ST_WR_LOW)
            cfg_q <= cfg_byte;
         if (state_d == ST_RD_LOW && state_q != ST_RD_LOW)
            cur_ch_q <= nxt_ch;
         if (state_q == ST_RD_LOW && tmr_done) begin
            res_valid        <= 1'b1;
            res_chan         <= cur_ch_q;
            res_data         <= bus_i;
            pend_q[cur_ch_q] <= 1'b0;
         end
         if (waiting && tmo_hit)
            pend_q <= '0;
      end
   end

   assign idle       = (state_q == ST_IDLE);
   assign cnv_start  = waiting ? pairs_q : '0;
   assign rd_n       = (state_q != ST_RD_LOW);
   assign wr_n       = (state_q != ST_WR_LOW);
   assign cs_n       = rd_n && wr_n;
   assign wr_byte_oe = (state_q == ST_WR_LOW);
   assign wr_byte    = wr_byte_oe ? cfg_q : '0;
endmodule

// File: rtl/adc6_host_ctrl_chk.sv
module adc6_host_ctrl_chk #(
   parameter int NP = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          res_valid,
   input logic          err_timeout,
   input logic [NP-1:0] cnv_start,
   input logic          adc_busy,
   input logic          cs_n,
   input logic          rd_n,
   input logic          wr_n,
   input logic          wr_byte_oe
);
   AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n)); // R6
   AST_CS_FRAMES: assert property (@(posedge clk) disable iff (!rst_n) (!rd_n || !wr_n) |-> !cs_n); // R5
   AST_NO_RD_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !adc_busy); // R3
   AST_QUIET_START: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> (cnv_start == '0)); // R3
   AST_OE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n) wr_byte_oe |-> !wr_n); // R6
   AST_VALID_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> $past(!rd_n)); // R4
   AST_ABORT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n) !(err_timeout && res_valid)); // R8
endmodule

bind adc6_host_ctrl adc6_host_ctrl_chk #(.NP(NUM_PAIRS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .res_valid   (res_valid),
   .err_timeout (err_timeout),
   .cnv_start   (cnv_start),
   .adc_busy    (adc_busy),
   .cs_n        (cs_n),
   .rd_n        (rd_n),
   .wr_n        (wr_n),
   .wr_byte_oe  (wr_byte_oe)
);

// File: tb/adc6_host_ctrl_test.sv
module adc6_host_ctrl_test;
   localparam int RDL = 3, WRL = 4, REC = 2, TMO = 200;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        conv_req = 1'b0, cfg_req = 1'b0, adc_busy = 1'b0;
   logic [2:0]  conv_pairs = '0, cnv_start, res_chan;
   logic [7:0]  cfg_byte = '0, wr_byte;
   logic        res_valid, err_reject, err_timeout, idle, cs_n, rd_n, wr_n, wr_byte_oe;
   logic [15:0] res_data, bus_i;

   int total = 0, bad = 0, cycles = 0;

   always #10 clk = ~clk;

   adc6_host_ctrl #(.RD_LOW_CYC(RDL), .WR_LOW_CYC(WRL), .RECOV_CYC(REC), .TIMEOUT_CYC(TMO)) uut (
      .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .conv_pairs(conv_pairs),
      .cfg_req(cfg_req), .cfg_byte(cfg_byte), .res_valid(res_valid), .res_chan(res_chan),
      .res_data(res_data), .err_reject(err_reject), .err_timeout(err_timeout), .idle(idle),
      .cnv_start(cnv_start), .adc_busy(adc_busy), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .wr_byte(wr_byte), .wr_byte_oe(wr_byte_oe), .bus_i(bus_i));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // behavioural converter
   int          conv_len = 10;
   logic [2:0]  start_q = '0;
   logic        rd_q = 1'b1;
   logic [15:0] samp [6];
   int          qch [6];
   int          qn = 0, qptr = 0, busy_left = 0;

   always @(posedge clk) begin
      logic [2:0] rise;
      rise = cnv_start & ~start_q;
      start_q <= cnv_start;
      rd_q    <= rd_n;
      if (!rd_q && rd_n) qptr <= qptr + 1;
      if (rise != 3'b000) begin
         int n;
         n = 0;
         for (int c = 0; c < 6; c++) begin
            samp[c] = 16'($urandom);
            if (rise[c/2]) begin qch[n] = c; n++; end
         end
         qn <= n; qptr <= 0;
         adc_busy <= 1'b1; busy_left <= conv_len;
      end else if (adc_busy) begin
         if (busy_left == 0) adc_busy <= 1'b0;
         else busy_left <= busy_left - 1;
      end
   end

   assign bus_i = (!cs_n && !rd_n && qptr < qn) ? samp[qch[qptr]] : 16'hDEAD;

   // expected-value helpers
   function automatic int exp_count(input logic [2:0] p);
      return 2 * (int'(p[0]) + int'(p[1]) + int'(p[2]));
   endfunction
   function automatic int exp_chan(input logic [2:0] p, input int k);
      int n = 0;
      for (int c = 0; c < 6; c++)
         if (p[c/2]) begin
            if (n == k) return c;
            n++;
         end
      return -1;
   endfunction

   // monitor
   logic [2:0] cur_pairs = '0;
   logic [7:0] exp_byte = '0;
   int got_n = 0, rd_run = 0, hi_run = 0, wr_run = 0, wr_count = 0;
   bit in_read = 0;

   always @(negedge clk) if (rst_n) begin
      if (res_valid) begin
         int ec;
         ec = exp_chan(cur_pairs, got_n);
         chk(int'(res_chan) == ec, "R4 channel order", int'(res_chan), ec);
         if (ec >= 0) chk(res_data == samp[ec], "R4 result data", int'(res_data), int'(samp[ec]));
         got_n++;
      end
      if (!rd_n && adc_busy) chk(0, "R3 read while busy", 1, 0);
      if (!rd_n) begin
         chk(!cs_n, "R5 cs_n low with rd_n", int'(cs_n), 0);
         if (rd_run == 0 && in_read) chk(hi_run == REC, "R5 recovery gap", hi_run, REC);
         rd_run++;
      end else begin
         if (rd_run > 0) begin
            chk(rd_run == RDL, "R5 read low time", rd_run, RDL);
            in_read = 1; hi_run = 0;
         end
         rd_run = 0;
         hi_run++;
      end
      if (!wr_n) begin
         if (wr_run == 0) chk(wr_byte_oe && !cs_n && wr_byte == exp_byte, "R6 write byte", int'(wr_byte), int'(exp_byte));
         wr_run++;
      end else begin
         if (wr_run > 0) begin
            chk(wr_run == WRL, "R6 write low time", wr_run, WRL);
            wr_count++;
         end
         wr_run = 0;
         if (wr_byte_oe) chk(0, "R6 bus driven outside write", 1, 0);
      end
   end

   task automatic do_conv(input logic [2:0] p, input int len, input bit exp_tmo,
                          input int inj, input bit with_cfg);
      int cyc, tmo_at, wr0;
      bit hold_bad;
      conv_len = len; cur_pairs = p; got_n = 0; in_read = 0;
      tmo_at = -1; hold_bad = 0; wr0 = wr_count;
      @(negedge clk);
      conv_req = 1'b1; conv_pairs = p;
      if (with_cfg) begin cfg_req = 1'b1; cfg_byte = 8'h5A; end
      @(negedge clk);
      conv_req = 1'b0; cfg_req = 1'b0;
      chk(cnv_start == p, "R2 start strobes", int'(cnv_start), int'(p));
      chk(!idle, "R10 idle low while converting", int'(idle), 0);
      cyc = 1;
      forever begin
         if (err_timeout) tmo_at = cyc;
         if (idle || cyc > 5000) break;
         if (adc_busy && !exp_tmo && cnv_start != p) hold_bad = 1;
         if (cyc == inj) begin conv_req = 1'b1; conv_pairs = 3'b111; end
         if (cyc == inj + 1) begin
            conv_req = 1'b0;
            chk(err_reject, "R7 reject while active", int'(err_reject), 1);
            chk(cnv_start == p, "R7 strobes unchanged", int'(cnv_start), int'(p));
         end
         @(negedge clk);
         cyc++;
      end
      if (exp_tmo) begin
         chk(tmo_at == TMO + 1, "R8 timeout cycle", tmo_at, TMO + 1);
         chk(got_n == 0, "R8 no results after abort", got_n, 0);
         chk(cnv_start == 3'b000, "R8 strobes cleared", int'(cnv_start), 0);
      end else begin
         chk(got_n == exp_count(p), "R4 result count", got_n, exp_count(p));
         chk(!hold_bad, "R2 strobes held while busy", int'(hold_bad), 0);
         chk(tmo_at == -1, "R8 no spurious timeout", tmo_at, -1);
      end
      if (with_cfg) chk(wr_count == wr0, "R9 write dropped", wr_count - wr0, 0);
      chk(idle, "R10 idle after operation", int'(idle), 1);
   endtask

   task automatic do_cfg(input logic [7:0] b);
      int wr0, cyc;
      wr0 = wr_count; exp_byte = b;
      @(negedge clk);
      cfg_req = 1'b1; cfg_byte = b;
      @(negedge clk);
      cfg_req = 1'b0;
      cyc = 0;
      while (!idle && cyc < 100) begin @(negedge clk); cyc++; end
      @(negedge clk);
      chk(wr_count == wr0 + 1, "R6 one write strobe", wr_count - wr0, 1);
   endtask

   task automatic reject_idle(input logic [2:0] p, input string req);
      @(negedge clk);
      conv_req = 1'b1; conv_pairs = p;
      @(negedge clk);
      conv_req = 1'b0;
      chk(err_reject, req, int'(err_reject), 1);
      chk(cnv_start == 3'b000 && idle, req, int'(cnv_start), 0);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=<150000", cycles);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk(cs_n && rd_n && wr_n && cnv_start == 3'b000 && !wr_byte_oe && !res_valid
          && !err_reject && !err_timeout && idle, "R1 reset state", int'(cnv_start), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(idle, "R10 idle after reset", int'(idle), 1);

      do_conv(3'b001, 5, 0, -10, 0);
      do_conv(3'b111, 12, 0, -10, 0);
      do_conv(3'b101, 1, 0, -10, 0);
      do_cfg(8'hA5);
      do_conv(3'b010, 20, 0, 4, 0);                 // R7 mid-conversion reject
      reject_idle(3'b000, "R7 empty pair mask");
      do_conv(3'b110, 8, 0, -10, 1);                // R9 priority
      do_conv(3'b011, TMO + 100, 1, -10, 0);         // R8 timeout
      reject_idle(3'b001, "R7 reject while busy high");
      while (adc_busy) @(negedge clk);

      for (int i = 0; i < 20; i++) begin
         if ($urandom_range(3) == 0) do_cfg(8'($urandom));
         else do_conv(3'($urandom_range(7, 1)), int'($urandom_range(40, 0)), 0, -10, 0);
      end

      repeat (4) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule